// File: doc/BRIEF.md
# Time-Calendar Counter

This block keeps wall-clock time and calendar date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle strobe on `upd_i`, normally one per second, starts an update. The status flag `uip_o` rises at once to warn software. After `UIP_LEAD` clock cycles the transfer happens: the time advances by one second and the software-visible bytes are refreshed.

Two copies of the time are held. The internal copy is kept in plain binary and always counts. The visible copy holds bytes in the format chosen by the control register: BCD or binary, and 12-hour or 24-hour hours. Setting the freeze bit stops the visible copy from changing, so software can rewrite the time safely. When the freeze bit is cleared, the internal copy is reloaded from the visible bytes. Software reaches all state through one address, a write strobe, write data and a combinational read port.

Top module: `rtc_calendar_core`

## Requirements
- R1: Register map: address 0 holds seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. Address 7 is control: bit 0 set selects binary and clear selects BCD, bit 1 set selects 24-hour and clear selects 12-hour, bit 7 is freeze; the other bits read 0. Address 8 is status, with bit 7 equal to `uip_o`. After reset, addresses 0..8 read 00,00,00,01,01,01,00,02,00.
- R2: In BCD mode each update adds one second. Seconds and minutes wrap after 59, hours wrap after 23, day of week runs 1..7, month runs 1..12 and year wraps from 99 to 00.
- R3: With control bit 0 set, every time and calendar byte counts in plain binary over the same ranges, for example 0x3B seconds → 0x00.
- R4: `uip_o` goes high in the cycle after the clock edge that samples `upd_i`. It stays high for exactly `UIP_LEAD` cycles. It falls in the same cycle that the visible bytes take the advanced time; before that they keep their old values.
- R5: While freeze is set, a strobe does not raise `uip_o`. Writing freeze to 1 during the warning window drops `uip_o` at the next cycle.
- R6: While freeze is set, transfers do not change the visible bytes, and bytes written by software stay as written. The internal copy keeps advancing.
- R7: Clearing freeze reloads the internal copy from the visible bytes, decoded with the newly written mode bits. The next update therefore continues from what software wrote.
- R8: The day of month wraps to 1 after 30 in months 4, 6, 9 and 11, and after 31 in the other months except February. February ends at 29 when the year value is divisible by 4 (00 counts as such a year) and at 28 otherwise.
- R9: In 12-hour mode hours run 1..12 and bit 7 of the hours byte marks PM. The hour sequence is 11 AM → 12 PM (BCD 0x92), 12 PM → 1 PM (0x81), 11 PM → 12 AM (0x12) with the day advancing, and 12 AM → 1 AM.
- R10: A write to a time byte while freeze is clear updates both copies, so the next second counts on from the written value.
- R11: A software write to a time byte in the same cycle as a transfer wins for that byte in both copies. The other bytes take their advanced values.
- R12: Writes to the status address have no effect. Status reads 0x80 while `uip_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | One-cycle update strobe, nominally once per second |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` (combinational) |
| uip_o | output | 1 | Update-in-progress warning flag |

## Verification
A software register write and the one-cycle transfer can land in the same clock cycle, and so can a freeze release and a transfer. The bench provokes the first case by counting `UIP_LEAD - 1` cycles after the strobe and then writing the minutes byte just as seconds roll over from 59. It judges the result by reading back 00 seconds with the written minutes, then checking that the following second keeps those minutes. Freezing in the middle of the warning window is provoked by writing the control register one cycle after `uip_o` rises. The bench then checks that the flag drops and that the visible seconds stay unchanged past the transfer point.

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int unsigned UIP_LEAD = 12200,
  parameter int unsigned AW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          uip_o
);

  localparam int unsigned CW = (UIP_LEAD > 1) ? $clog2(UIP_LEAD) : 1;
  localparam logic [CW-1:0] LAST = CW'(UIP_LEAD - 1);
  localparam logic [AW-1:0] A_SEC  = AW'(0);
  localparam logic [AW-1:0] A_MIN  = AW'(1);
  localparam logic [AW-1:0] A_HR   = AW'(2);
  localparam logic [AW-1:0] A_DOW  = AW'(3);
  localparam logic [AW-1:0] A_DOM  = AW'(4);
  localparam logic [AW-1:0] A_MON  = AW'(5);
  localparam logic [AW-1:0] A_YR   = AW'(6);
  localparam logic [AW-1:0] A_CTRL = AW'(7);
  localparam logic [AW-1:0] A_STAT = AW'(8);

  function automatic logic [6:0] dec(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : 7'(7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    logic [6:0] t;
    t = v / 7'd10;
    return bin ? {1'b0, v} : {t[3:0], 4'(v - t * 7'd10)};
  endfunction

  function automatic logic [4:0] hdec(input logic [7:0] b, input logic bin, input logic h24);
    logic [6:0] v;
    if (h24) begin
      v = dec(b, bin);
      return v[4:0];
    end
    v = dec({1'b0, b[6:0]}, bin);
    if (v == 7'd12) return b[7] ? 5'd12 : 5'd0;
    return b[7] ? 5'(v + 7'd12) : v[4:0];
  endfunction

  function automatic logic [7:0] henc(input logic [4:0] h, input logic bin, input logic h24);
    logic [4:0] h12;
    logic [7:0] e;
    if (h24) return enc({2'b0, h}, bin);
    h12 = (h == 5'd0) ? 5'd12 : ((h > 5'd12) ? h - 5'd12 : h);
    e   = enc({2'b0, h12}, bin);
    return {(h >= 5'd12), e[6:0]};
  endfunction

  function automatic logic [4:0] dim(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                   return (y[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction

  logic          set_q, bin_q, h24_q;
  logic          pend_q, uip_q;
  logic [CW-1:0] cnt_q;
  logic [6:0]    i_sec, i_min, i_yr;
  logic [4:0]    i_hr, i_dom;
  logic [2:0]    i_dow;
  logic [3:0]    i_mon;
  logic [7:0]    u_q [7];

  wire ctrl_wr = we_i && (addr_i == A_CTRL);
  wire frz_n   = ctrl_wr ? wdata_i[7] : set_q;
  wire reload  = ctrl_wr && set_q && !wdata_i[7];
  wire live_wr = we_i && !set_q;
  wire xfer    = pend_q && (cnt_q == LAST);
  wire load_u  = xfer && !frz_n && !reload;

  logic [6:0] n_sec, n_min, n_yr;
  logic [4:0] n_hr, n_dom;
  logic [2:0] n_dow;
  logic [3:0] n_mon;
  logic       c_s, c_m, c_h, c_d, c_mo;

  always_comb begin
    c_s   = i_sec >= 7'd59;
    c_m   = c_s && (i_min >= 7'd59);
    c_h   = c_m && (i_hr >= 5'd23);
    c_d   = c_h && (i_dom >= dim(i_mon, i_yr));
    c_mo  = c_d && (i_mon >= 4'd12);
    n_sec = c_s ? 7'd0 : i_sec + 7'd1;
    n_min = c_s ? (c_m ? 7'd0 : i_min + 7'd1) : i_min;
    n_hr  = c_m ? (c_h ? 5'd0 : i_hr + 5'd1) : i_hr;
    n_dow = c_h ? ((i_dow >= 3'd7) ? 3'd1 : i_dow + 3'd1) : i_dow;
    n_dom = c_h ? (c_d ? 5'd1 : i_dom + 5'd1) : i_dom;
    n_mon = c_d ? (c_mo ? 4'd1 : i_mon + 4'd1) : i_mon;
    n_yr  = c_mo ? ((i_yr >= 7'd99) ? 7'd0 : i_yr + 7'd1) : i_yr;
  end

  logic [7:0] enc_n [7];
  always_comb begin
    enc_n[0] = enc(n_sec, bin_q);
    enc_n[1] = enc(n_min, bin_q);
    enc_n[2] = henc(n_hr, bin_q, h24_q);
    enc_n[3] = enc({4'b0, n_dow}, bin_q);
    enc_n[4] = enc({2'b0, n_dom}, bin_q);
    enc_n[5] = enc({3'b0, n_mon}, bin_q);
    enc_n[6] = enc(n_yr, bin_q);
  end

  logic [6:0] wd, r_sec, r_min, r_dow, r_dom, r_mon, r_yr;
  logic [4:0] wh, r_hr;
  always_comb begin
    wd    = dec(wdata_i, bin_q);
    wh    = hdec(wdata_i, bin_q, h24_q);
    r_sec = dec(u_q[0], wdata_i[0]);
    r_min = dec(u_q[1], wdata_i[0]);
    r_hr  = hdec(u_q[2], wdata_i[0], wdata_i[1]);
    r_dow = dec(u_q[3], wdata_i[0]);
    r_dom = dec(u_q[4], wdata_i[0]);
    r_mon = dec(u_q[5], wdata_i[0]);
    r_yr  = dec(u_q[6], wdata_i[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q <= 1'b0;
      bin_q <= 1'b0;
      h24_q <= 1'b1;
    end else if (ctrl_wr) begin
      set_q <= wdata_i[7];
      bin_q <= wdata_i[0];
      h24_q <= wdata_i[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      uip_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_i && !pend_q) begin
      pend_q <= 1'b1;
      uip_q  <= !frz_n;
      cnt_q  <= '0;
    end else if (pend_q) begin
      if (xfer) begin
        pend_q <= 1'b0;
        uip_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
        if (frz_n) uip_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_sec <= 7'd0;
      i_min <= 7'd0;
      i_hr  <= 5'd0;
      i_dow <= 3'd1;
      i_dom <= 5'd1;
      i_mon <= 4'd1;
      i_yr  <= 7'd0;
    end else if (reload) begin
      i_sec <= r_sec;
      i_min <= r_min;
      i_hr  <= r_hr;
      i_dow <= r_dow[2:0];
      i_dom <= r_dom[4:0];
      i_mon <= r_mon[3:0];
      i_yr  <= r_yr;
    end else begin
      if (xfer) begin
        i_sec <= n_sec;
        i_min <= n_min;
        i_hr  <= n_hr;
        i_dow <= n_dow;
        i_dom <= n_dom;
        i_mon <= n_mon;
        i_yr  <= n_yr;
      end
      if (live_wr) begin
        case (addr_i)
          A_SEC:   i_sec <= wd;
          A_MIN:   i_min <= wd;
          A_HR:    i_hr  <= wh;
          A_DOW:   i_dow <= wd[2:0];
          A_DOM:   i_dom <= wd[4:0];
          A_MON:   i_mon <= wd[3:0];
          A_YR:    i_yr  <= wd;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_q[0] <= 8'h00;
      u_q[1] <= 8'h00;
      u_q[2] <= 8'h00;
      u_q[3] <= 8'h01;
      u_q[4] <= 8'h01;
      u_q[5] <= 8'h01;
      u_q[6] <= 8'h00;
    end else begin
      if (load_u)
        for (int k = 0; k < 7; k++) u_q[k] <= enc_n[k];
      if (we_i && (addr_i < A_CTRL))
        u_q[addr_i[2:0]] <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_SEC, A_MIN, A_HR, A_DOW, A_DOM, A_MON, A_YR: rdata_o = u_q[addr_i[2:0]];
      A_CTRL:  rdata_o = {set_q, 5'b0, h24_q, bin_q};
      A_STAT:  rdata_o = {uip_q, 7'b0};
      default: rdata_o = 8'h00;
    endcase
  end

  assign uip_o = uip_q;

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic          uip_o,
  input logic          pend,
  input logic          xfer,
  input logic          set_q,
  input logic [6:0]    int_sec,
  input logic [7:0]    usr_sec
);

  wire touch = we_i && ((addr_i == AW'(0)) || (addr_i == AW'(7)));

  AST_UIP_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    uip_o |-> pend); // R4

  AST_UIP_FALLS_AT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(uip_o) && !set_q) |-> $past(xfer)); // R4

  AST_FREEZE_NO_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    set_q |-> !uip_o); // R5

  AST_FROZEN_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && set_q && !touch) |=> $stable(usr_sec)); // R6

  AST_INTERNAL_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !touch) |=> (int_sec != $past(int_sec))); // R6

endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .uip_o   (uip_o),
  .pend    (pend_q),
  .xfer    (xfer),
  .set_q   (set_q),
  .int_sec (i_sec),
  .usr_sec (u_q[0])
);

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
  localparam int L = 6;
  localparam int NV = 13;
  // {ctrl, sec..year start, sec..year expected}
  localparam logic [119:0] VEC [NV] = '{
    {8'h02, 56'h12_34_05_03_15_06_23, 56'h13_34_05_03_15_06_23},
    {8'h02, 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00},
    {8'h02, 56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},
    {8'h02, 56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},
    {8'h03, 56'h3B_3B_17_05_1D_02_30, 56'h00_00_00_06_01_03_30},
    {8'h02, 56'h59_59_23_01_30_04_10, 56'h00_00_00_02_01_05_10},
    {8'h00, 56'h59_59_11_04_10_05_07, 56'h00_00_92_04_10_05_07},
    {8'h00, 56'h59_59_91_04_10_05_07, 56'h00_00_12_05_11_05_07},
    {8'h00, 56'h59_59_92_04_10_05_07, 56'h00_00_81_04_10_05_07},
    {8'h01, 56'h3B_3B_8B_07_1F_0C_63, 56'h00_00_0C_01_01_01_00},
    {8'h03, 56'h3B_0A_0F_02_05_06_07, 56'h00_0B_0F_02_05_06_07},
    {8'h00, 56'h59_59_12_04_10_05_07, 56'h00_00_01_04_10_05_07},
    {8'h02, 56'h59_59_23_02_29_02_00, 56'h00_00_00_03_01_03_00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_i = 1'b0;
  logic       we_i = 1'b0;
  logic [3:0] addr_i = 4'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       uip_o;
  int total = 0;
  int bad = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  rtc_calendar_core #(.UIP_LEAD(L), .AW(4)) i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .uip_o(uip_o));

  function automatic string vreq(int i);
    case (i)
      0, 1:          return "R2";
      4, 10:         return "R3";
      2, 3, 5, 12:   return "R8";
      default:       return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic tick;
    @(negedge clk);
    upd_i = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
  endtask

  task automatic tick_full;
    tick();
    repeat (L) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R4 actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset map
    rd(0, v); chk("R1 sec", v, 8'h00);
    rd(1, v); chk("R1 min", v, 8'h00);
    rd(2, v); chk("R1 hour", v, 8'h00);
    rd(3, v); chk("R1 dow", v, 8'h01);
    rd(4, v); chk("R1 dom", v, 8'h01);
    rd(5, v); chk("R1 month", v, 8'h01);
    rd(6, v); chk("R1 year", v, 8'h00);
    rd(7, v); chk("R1 ctrl", v, 8'h02);
    rd(8, v); chk("R1 status", v, 8'h00);

    // R4 warning window
    addr_i = 4'd8;
    tick();
    #1 chk("R4 uip rise", {7'b0, uip_o}, 8'h01);
    chk("R12 status uip", rdata_o, 8'h80);
    addr_i = 4'd0;
    repeat (L - 1) @(negedge clk);
    #1 chk("R4 uip held", {7'b0, uip_o}, 8'h01);
    chk("R4 sec before xfer", rdata_o, 8'h00);
    @(negedge clk);
    #1 chk("R4 uip fall", {7'b0, uip_o}, 8'h00);
    chk("R4 sec after xfer", rdata_o, 8'h01);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      wr(7, 8'h80 | VEC[i][119:112]);
      for (int b = 0; b < 7; b++) wr(4'(b), VEC[i][111 - 8*b -: 8]);
      wr(7, VEC[i][119:112]);
      tick_full();
      for (int b = 0; b < 7; b++) begin
        rd(4'(b), v);
        chk(vreq(i), v, VEC[i][55 - 8*b -: 8]);
      end
    end

    // R10 live write in BCD 24h
    wr(7, 8'h02);
    wr(0, 8'h30);
    tick_full();
    rd(0, v); chk("R10 live write", v, 8'h31);

    // R11 write in transfer cycle
    wr(7, 8'h82); wr(0, 8'h59); wr(1, 8'h10); wr(7, 8'h02);
    tick();
    repeat (L - 1) @(negedge clk);
    we_i = 1'b1; addr_i = 4'd1; wdata_i = 8'h45;
    @(negedge clk);
    we_i = 1'b0;
    rd(0, v); chk("R11 sec advanced", v, 8'h00);
    rd(1, v); chk("R11 min write wins", v, 8'h45);
    tick_full();
    rd(1, v); chk("R11 min kept internally", v, 8'h45);
    rd(0, v); chk("R11 sec next", v, 8'h01);

    // R5 R6 R7 freeze and release
    wr(7, 8'h82);
    tick();
    #1 chk("R5 no uip when frozen", {7'b0, uip_o}, 8'h00);
    repeat (L) @(negedge clk);
    rd(0, v); chk("R6 frozen sec", v, 8'h01);
    wr(0, 8'h20);
    tick_full();
    rd(0, v); chk("R6 written byte kept", v, 8'h20);
    wr(7, 8'h02);
    tick_full();
    rd(0, v); chk("R7 resume from user", v, 8'h21);
    rd(1, v); chk("R7 min from user", v, 8'h45);

    // R5 freeze inside warning window
    tick();
    @(negedge clk);
    we_i = 1'b1; addr_i = 4'd7; wdata_i = 8'h82;
    @(negedge clk);
    we_i = 1'b0;
    #1 chk("R5 uip cleared", {7'b0, uip_o}, 8'h00);
    repeat (L - 1) @(negedge clk);
    rd(0, v); chk("R6 no transfer after freeze", v, 8'h21);
    wr(7, 8'h02);

    // R12 status is read-only
    wr(8, 8'hFF);
    rd(8, v); chk("R12 status write ignored", v, 8'h00);
    rd(7, v); chk("R12 ctrl untouched", v, 8'h02);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule